// File: doc/BRIEF.md
# Two-Bit Zero-Lag Cross-Correlation Matrix

This block correlates two groups of parallel sample streams. Group A and group B each carry `N_CH` channels, and every channel delivers one 2-bit quantized sample on every clock. For each pair made of one A channel and one B channel, the block multiplies the two current samples, with no relative delay between them. It adds the product to a signed accumulator for that pair. The result is an `N_CH` x `N_CH` matrix of `ACC_W`-bit sums, built up over an integration period set by software.

Integration periods run back to back. On the last cycle of a period, the completed sums (including that cycle's product) are copied into a shadow bank. In the same edge the accumulators restart, so the next sample already belongs to the new period and no sample is lost. The shadow bank is then streamed out one byte at a time while the next period accumulates. The `rd_step` strobe paces the byte stream, so a slower readout rate can be imposed from outside.

Top module: `xcorr_matrix`

## Requirements
- R1: Sample encoding. Bit 1 of a channel's 2-bit field is the sign (1 = negative) and bit 0 is the magnitude (0 = 1, 1 = 3), so 00=+1, 01=+3, 10=-1, 11=-3. Channel i occupies bits [2i+1:2i]. Every cycle, cell (i,j) adds level(A_i) x level(B_j).
- R2: An integration period lasts `period_len`+1 clock cycles. `period_len` is sampled during reset and again at every period boundary.
- R3: Periods follow each other with no gap. Each sample cycle counts in exactly one frame, and the first cycle after reset starts the first period.
- R4: The snapshot is taken at the clock edge that ends a period. If `rd_step` is held high, the first byte appears one cycle after that edge. Each subsequent byte is registered at an edge where `rd_step` was high in the preceding cycle, and `out_vld` is high only in those cycles.
- R5: Bytes leave in row-major order (A index outer, B index inner), least significant byte first, `ACC_W`/8 bytes per cell. `out_sof` is high with the first byte of a frame only, and `out_vld` stays low when no frame is being sent.
- R6: An accumulator saturates at the signed `ACC_W`-bit limits instead of wrapping.
- R7: `frame_ovf` is updated at each accepted snapshot. It goes high if any cell saturated during that period and stays at that value until the next accepted snapshot.
- R8: If a period ends while a frame is still being sent, `overrun` pulses for one cycle. The new sums are discarded, and the frame being sent continues unchanged.
- R9: While `rst` is high, `out_vld`, `out_sof`, `frame_ovf` and `overrun` are low, all accumulators are cleared, and no readout is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and readout clock |
| rst | input | 1 | Synchronous active-high reset |
| period_len | input | PER_W | Integration length minus one, in cycles |
| a_smp | input | 2*N_CH | Group A samples, 2 bits per channel |
| b_smp | input | 2*N_CH | Group B samples, 2 bits per channel |
| rd_step | input | 1 | Readout pacing strobe, one byte per high cycle |
| out_vld | output | 1 | Byte valid |
| out_sof | output | 1 | First byte of a frame |
| out_byte | output | 8 | Readout byte |
| frame_ovf | output | 1 | Some cell saturated in the frame being held |
| overrun | output | 1 | One-cycle pulse: a snapshot was dropped |

## Verification
A sample driven before edge k is in the accumulators after edge k. When edge k closes a period, that sample is in the shadow bank from the same edge. Byte 0 is then registered at edge k+1, and byte n follows n paced cycles later. The overrun pulse and the `frame_ovf` update are both visible one edge after the boundary. The bench drives inputs on falling edges and counts the edges after the last sample of each period. It checks the latency at the exact cycle, and it waits a further delay step before sampling, so its monitor and its checks never race.

// File: rtl/xc_pkg.sv
package xc_pkg;

  // signed level carried by one 2-bit sample: bit1 = sign, bit0 = magnitude
  function automatic logic signed [4:0] xc_level(input logic [1:0] s);
    logic signed [4:0] mag;
    mag = s[0] ? 5'sd3 : 5'sd1;
    return s[1] ? -mag : mag;
  endfunction

  // product of two levels, range {-9,-3,-1,+1,+3,+9}
  function automatic logic signed [4:0] xc_mul(input logic [1:0] a, input logic [1:0] b);
    logic signed [4:0] la;
    logic signed [4:0] lb;
    la = xc_level(a);
    lb = xc_level(b);
    return la * lb;
  endfunction

endpackage

// File: rtl/xc_period.sv
module xc_period #(
  parameter int PER_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] len_m1,
  output logic             last
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] len_q;

  assign last = (cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= len_m1;
    end else if (last) begin
      cnt_q <= '0;
      len_q <= len_m1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a period boundary always restarts the count at zero
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    last |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/xc_cell.sv
module xc_cell #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       a,
  input  logic [1:0]       b,
  input  logic             last,
  output logic [ACC_W-1:0] sum_nxt,
  output logic             ovf_nxt
);
  import xc_pkg::*;

  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;
  logic signed [4:0] prod;
  logic [ACC_W:0]   ext;
  logic             hit;

  assign prod = xc_mul(a, b);
  assign ext  = {acc_q[ACC_W-1], acc_q} + {{(ACC_W-4){prod[4]}}, prod};
  assign hit  = ext[ACC_W] ^ ext[ACC_W-1];

  always_comb begin
    if (hit) sum_nxt = ext[ACC_W] ? MINV : MAXV;
    else     sum_nxt = ext[ACC_W-1:0];
    ovf_nxt = ovf_q | hit;
  end

  always_ff @(posedge clk) begin
    if (rst || last) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= sum_nxt;
      ovf_q <= ovf_nxt;
    end
  end

  // a full-scale sum never wraps on a further positive product
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!last && acc_q == MAXV && prod > 0) |=> (acc_q == MAXV)); // R6

endmodule

// File: rtl/xc_readout.sv
module xc_readout #(
  parameter int NC    = 64,
  parameter int ACC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last,
  input  logic              ovf_any,
  input  logic [NC*ACC_W-1:0] sums,
  input  logic              rd_step,
  output logic              out_vld,
  output logic              out_sof,
  output logic [7:0]        out_byte,
  output logic              frame_ovf,
  output logic              overrun
);

  localparam int NB    = NC * ACC_W / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  logic [NC*ACC_W-1:0] shadow_q;
  logic                busy_q;
  logic [IDX_W-1:0]    idx_q;
  logic                take;
  logic                drop;

  assign take = last & ~busy_q;
  assign drop = last &  busy_q;

  // shadow bank: written only when a frame is accepted
  always_ff @(posedge clk) begin
    if (rst)       shadow_q <= '0;
    else if (take) shadow_q <= sums;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      out_vld   <= 1'b0;
      out_sof   <= 1'b0;
      out_byte  <= '0;
      frame_ovf <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      out_sof <= 1'b0;
      overrun <= drop;
      if (busy_q && rd_step) begin
        out_vld  <= 1'b1;
        out_sof  <= (idx_q == '0);
        out_byte <= shadow_q[{idx_q, 3'b000} +: 8];
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end
      if (take) begin
        busy_q    <= 1'b1;
        idx_q     <= '0;
        frame_ovf <= ovf_any;
      end
    end
  end

  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(shadow_q)); // R8
  AST_VLD_PACE: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(rd_step)); // R4
  AST_SOF_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_vld); // R5

endmodule

// File: rtl/xcorr_matrix.sv
module xcorr_matrix #(
  parameter int N_CH  = 8,
  parameter int ACC_W = 32,
  parameter int PER_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  period_len,
  input  logic [2*N_CH-1:0] a_smp,
  input  logic [2*N_CH-1:0] b_smp,
  input  logic              rd_step,
  output logic              out_vld,
  output logic              out_sof,
  output logic [7:0]        out_byte,
  output logic              frame_ovf,
  output logic              overrun
);

  localparam int NC = N_CH * N_CH;

  logic                last;
  logic [NC*ACC_W-1:0] sum_flat;
  logic [NC-1:0]       ovf_vec;

  xc_period #(.PER_W(PER_W)) u_period (
    .clk    (clk),
    .rst    (rst),
    .len_m1 (period_len),
    .last   (last)
  );

  // cell (i,j) sits at flat position i*N_CH+j: row-major, A outer
  for (genvar gi = 0; gi < N_CH; gi++) begin : g_row
    for (genvar gj = 0; gj < N_CH; gj++) begin : g_col
      localparam int C = gi * N_CH + gj;
      xc_cell #(.ACC_W(ACC_W)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .a       (a_smp[2*gi +: 2]),
        .b       (b_smp[2*gj +: 2]),
        .last    (last),
        .sum_nxt (sum_flat[C*ACC_W +: ACC_W]),
        .ovf_nxt (ovf_vec[C])
      );
    end
  end

  xc_readout #(.NC(NC), .ACC_W(ACC_W)) u_readout (
    .clk       (clk),
    .rst       (rst),
    .last      (last),
    .ovf_any   (|ovf_vec),
    .sums      (sum_flat),
    .rd_step   (rd_step),
    .out_vld   (out_vld),
    .out_sof   (out_sof),
    .out_byte  (out_byte),
    .frame_ovf (frame_ovf),
    .overrun   (overrun)
  );

endmodule

// File: tb/tb_xcorr_matrix.sv
module tb_xcorr_matrix;

  localparam int N  = 3;
  localparam int AW = 16;
  localparam int PW = 16;
  localparam int NC = N * N;
  localparam int NB = NC * AW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0]  period_len = '0;
  logic [2*N-1:0] a_smp = '0;
  logic [2*N-1:0] b_smp = '0;
  logic rd_step = 1'b1;
  logic out_vld, out_sof, frame_ovf, overrun;
  logic [7:0] out_byte;

  always #4 clk = ~clk;

  xcorr_matrix #(.N_CH(N), .ACC_W(AW), .PER_W(PW)) dut (
    .clk(clk), .rst(rst), .period_len(period_len), .a_smp(a_smp), .b_smp(b_smp),
    .rd_step(rd_step), .out_vld(out_vld), .out_sof(out_sof), .out_byte(out_byte),
    .frame_ovf(frame_ovf), .overrun(overrun)
  );

  int n_vec = 0;
  int n_bad = 0;
  int m1[NC];
  int m2[NC];
  logic [7:0] cap_b[64];
  logic       cap_s[64];
  int ncap = 0;
  int novr = 0;
  int stepcnt = 0;
  bit pace = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst && out_vld && ncap < 64) begin
      cap_b[ncap] = out_byte;
      cap_s[ncap] = out_sof;
      ncap++;
    end
    if (!rst && overrun) novr++;
  end

  function automatic int lev(input logic [1:0] s);
    int m;
    m = s[0] ? 3 : 1;
    return s[1] ? -m : m;
  endfunction

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int plen);
    @(negedge clk);
    rst = 1'b1;
    period_len = PW'(plen);
    pace = 0;
    rd_step = 1'b1;
    a_smp = '0;
    b_smp = '0;
    repeat (3) @(negedge clk);
    ncap = 0;
    novr = 0;
    stepcnt = 0;
    for (int c = 0; c < NC; c++) begin
      m1[c] = 0;
      m2[c] = 0;
    end
  endtask

  // drive one sample cycle; sel picks which model frame it belongs to
  task automatic step(input logic [2*N-1:0] a, input logic [2*N-1:0] b, input int sel);
    @(negedge clk);
    rst = 1'b0;
    a_smp = a;
    b_smp = b;
    rd_step = pace ? stepcnt[0] : 1'b1;
    stepcnt++;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int p;
        p = lev(a[2*i +: 2]) * lev(b[2*j +: 2]);
        if (sel == 1) m1[i*N+j] = sat(m1[i*N+j] + p);
        if (sel == 2) m2[i*N+j] = sat(m2[i*N+j] + p);
      end
  endtask

  task automatic check_frame(input int base, input int sel, input string tag);
    for (int k = 0; k < NB; k++) begin
      int v;
      int e;
      v = (sel == 1) ? m1[k/2] : m2[k/2];
      e = (v >> (8 * (k % 2))) & 255;
      chk(cap_b[base+k] == 8'(e), {tag, " R1 R5 byte"}, int'(cap_b[base+k]), e);
      chk(cap_s[base+k] == (k == 0), {tag, " R5 sof"}, int'(cap_s[base+k]), int'(k == 0));
    end
  endtask

  function automatic logic [2*N-1:0] pat_a(input int t);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = 2'((t * 3 + i) & 3);
    return r;
  endfunction

  function automatic logic [2*N-1:0] pat_b(input int t);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = 2'((t * 5 + 2 * i + 1) & 3);
    return r;
  endfunction

  task automatic t_reset();
    do_reset(10);
    #1;
    chk(out_vld == 1'b0, "R9 out_vld in reset", int'(out_vld), 0);
    chk(out_sof == 1'b0, "R9 out_sof in reset", int'(out_sof), 0);
    chk(frame_ovf == 1'b0, "R9 frame_ovf in reset", int'(frame_ovf), 0);
    chk(overrun == 1'b0, "R9 overrun in reset", int'(overrun), 0);
  endtask

  // constant inputs, latency of the first byte, one full frame
  task automatic t_basic();
    do_reset(23);
    for (int t = 0; t < 24; t++) step(6'b010101, 6'b101100, 1);
    step(6'b010101, 6'b101100, 0);
    #1;
    chk(out_vld == 1'b0, "R4 no byte on capture edge", int'(out_vld), 0);
    step(6'b010101, 6'b101100, 0);
    #1;
    chk(out_vld == 1'b1, "R4 first byte one cycle later", int'(out_vld), 1);
    chk(out_sof == 1'b1, "R5 sof on first byte", int'(out_sof), 1);
    chk(out_byte == 8'd72, "R1 R2 first byte", int'(out_byte), 72);
    for (int t = 0; t < 20; t++) step(6'b010101, 6'b101100, 0);
    #1;
    chk(ncap == NB, "R5 byte count and idle valid", ncap, NB);
    check_frame(0, 1, "basic");
  endtask

  // varying inputs over two back-to-back periods
  task automatic t_seamless();
    do_reset(29);
    for (int t = 0; t < 30; t++) step(pat_a(t), pat_b(t), 1);
    for (int t = 30; t < 60; t++) step(pat_a(t), pat_b(t), 2);
    for (int t = 60; t < 82; t++) step(pat_a(t), pat_b(t), 0);
    #1;
    chk(ncap == 2 * NB, "R3 two frames delivered", ncap, 2 * NB);
    chk(novr == 0, "R8 no overrun when readout keeps up", novr, 0);
    check_frame(0, 1, "R3 frame1");
    check_frame(NB, 2, "R3 frame2");
  endtask

  // rd_step toggling paces the byte stream
  task automatic t_pace();
    do_reset(49);
    pace = 1;
    for (int t = 0; t < 50; t++) step(pat_b(t), pat_a(t), 1);
    for (int t = 50; t < 70; t++) step(pat_b(t), pat_a(t), 0);
    #1;
    chk(ncap >= 8 && ncap <= 11, "R4 paced byte rate", ncap, 10);
    for (int t = 70; t < 99; t++) step(pat_b(t), pat_a(t), 0);
    #1;
    chk(ncap == NB, "R4 paced frame complete", ncap, NB);
    check_frame(0, 1, "R4 paced");
  endtask

  // one-cycle periods: snapshots arrive while busy
  task automatic t_overrun();
    do_reset(0);
    step(6'b011000, 6'b110100, 1);
    for (int t = 0; t < 19; t++) step(6'b111111, 6'b111111, 0);
    #1;
    chk(novr == 18, "R8 overrun pulses", novr, 18);
    chk(ncap == NB, "R8 single frame sent", ncap, NB);
    chk(frame_ovf == 1'b0, "R7 no saturation flag", int'(frame_ovf), 0);
    check_frame(0, 1, "R8 older frame kept");
  endtask

  // saturation at both limits, flag set then cleared
  task automatic t_saturate();
    do_reset(3999);
    for (int t = 0; t < 4000; t++) step(6'b111111, 6'b000111, 1);
    step(6'b000000, 6'b000000, 2);
    #1;
    chk(frame_ovf == 1'b1, "R7 saturated frame flagged", int'(frame_ovf), 1);
    chk(m1[0] == 32767 && m1[1] == -32768, "R6 model limits", m1[1], -32768);
    for (int t = 1; t < 4000; t++) step(6'b000000, 6'b000000, 2);
    for (int t = 0; t < 20; t++) step(6'b000000, 6'b000000, 0);
    #1;
    chk(frame_ovf == 1'b0, "R7 flag cleared on clean frame", int'(frame_ovf), 0);
    chk(ncap == 2 * NB, "R6 both frames sent", ncap, 2 * NB);
    check_frame(0, 1, "R6 saturated");
    check_frame(NB, 2, "R6 clean");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_seamless();
    t_pace();
    t_overrun();
    t_saturate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule